// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static memory whose shared data bus can switch between reads and writes with no idle cycle. A command (address, direction and chip selects) is taken on a rising edge. Its data moves in the cycle that follows. Write data is registered on the next edge. Read data reaches `dout` through a combinational flow-through path with no output register. An internal two-bit counter turns one presented address into a burst of four beats, in linear or interleaved order. A clock-enable pin and a sleep pin both freeze the block as if the edge had not occurred.

The bidirectional bus is split into `din`, `dout` and `dout_drive`, which is the high-impedance control of a pad. Write data is held for one extra edge in a staging register before it reaches the array. A read that hits the staged word takes the staged lanes from that register. The data path has no valid/ready handshake. The data phase always falls in the cycle after its command, and the only way to stall is to raise `run_n` or `doze`. The array depth is a parameter, `MEM_AW`, so a small memory can be used in simulation while the address port keeps its full width.

Top module: `zbt_sram`

## Requirements
- R1: A command is accepted on a rising edge when `run_n`=0, `doze`=0, `load_n`=0 and all three selects are true (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0). `rd_wr`=1 means read and `rd_wr`=0 means write.
- R2: The write data for an accepted write beat is taken from `din` on the next enabled edge. A later read of that address returns it.
- R3: In the cycle after an accepted read beat, `dout_drive` is 1 (with `out_en_n`=0) and `dout` shows the word at the beat address without a further edge.
- R4: An edge with `load_n`=1 during a live burst advances it. With `burst_il`=0 the low two address bits run start, start+1, start+2, start+3 modulo 4, and the upper bits stay fixed.
- R5: With `burst_il`=1 the low two bits of beat n are start XOR n, for n = 0..3.
- R6: An edge with `run_n`=1 changes no state: `dout`, `dout_drive` and the array stay as they were, and `din` and `addr` are ignored.
- R7: An edge with `load_n`=0 and any select false ends a live burst and drives the bus off in the next cycle. A write beat accepted on the edge before still gets its data. A later advance edge then starts nothing.
- R8: `dout_drive` is 0 in the cycle after an accepted write beat, and a read may be issued on the very next edge.
- R9: Lane i (bits 9i+8..9i) is written only when `lane_wr_n[i]`=0 on that beat's command edge. Unwritten lanes keep their old contents.
- R10: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the old ones.
- R11: `out_en_n`=1 forces `dout_drive` to 0 at once, without waiting for a clock edge.
- R12: An edge with `doze`=1 behaves like one with `run_n`=1, and the array contents are kept.
- R13: While `rst_n`=0 and after it is released, no burst is live and `dout_drive` is 0 until a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| run_n | input | 1 | Active-low clock enable |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 loads a new command, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write (sampled on load) |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| burst_il | input | 1 | Static burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| doze | input | 1 | Sleep: freezes operation, keeps contents |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_drive | output | 1 | Pad drive enable for `dout` |

## Verification
The properties assume that `burst_il` changes only while no burst is live, and that every control input has a known value on each edge after reset. The bench changes the order pin only after a deselect edge, and it drives all inputs 2 ns after a rising edge, so every edge sees settled values. It keeps addresses inside the reduced array depth so that aliasing never affects the forwarding compare. It writes the whole array before it reads anything.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

  // Low two address bits of burst beat `beat` starting at `start`.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input burst_order_e ord);
    logic [1:0] res;
    if (ord == ORD_INTERLEAVED) res = start ^ beat;
    else                        res = start + beat;
    return res;
  endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic              stop,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_il,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              live
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              live_q;
  burst_order_e      ord;

  assign ord = burst_order_e'(order_il);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      live_q <= 1'b0;
    end else if (step) begin
      if (load) begin
        base_q <= addr_in;
        beat_q <= 2'd0;
        live_q <= 1'b1;
      end else if (stop) begin
        live_q <= 1'b0;
      end else if (live_q) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], beat_q, ord)};
  assign live     = live_q;

endmodule

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_n,
  input  logic             sel_ok,
  input  logic             rd_wr,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             live,
  output logic             load,
  output logic             stop,
  output logic             acc_valid,
  output logic             acc_write,
  output logic [LANES-1:0] acc_mask
);

  logic             valid_q;
  logic             write_q;
  logic [LANES-1:0] mask_q;

  assign load = ~load_n & sel_ok;
  assign stop = ~load_n & ~sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      mask_q  <= '0;
    end else if (step) begin
      valid_q <= load | (load_n & live);
      if (load) write_q <= ~rd_wr;
      mask_q <= ~lane_wr_n;
    end
  end

  assign acc_valid = valid_q;
  assign acc_write = write_q;
  assign acc_mask  = mask_q;

endmodule

// File: rtl/zbt_wr_stage.sv
module zbt_wr_stage #(
  parameter int ADDR_W = 18,
  parameter int ARR_AW = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DW-1:0]     cap_data,
  input  logic [LANES-1:0]  cap_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     arr_data,
  output logic [LANES-1:0]  commit_we,
  output logic [ARR_AW-1:0] commit_addr,
  output logic [DW-1:0]     commit_data,
  output logic [DW-1:0]     rd_data
);

  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [DW-1:0]     pend_data;
  logic [LANES-1:0]  pend_mask;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_valid <= 1'b0;
    else if (step) pend_valid <= capture;
  end

  always_ff @(posedge clk) begin
    if (step) begin
      pend_addr <= cap_addr;
      pend_data <= cap_data;
      pend_mask <= cap_mask;
    end
  end

  assign commit_we   = {LANES{pend_valid & step}} & pend_mask;
  assign commit_addr = pend_addr[ARR_AW-1:0];
  assign commit_data = pend_data;
  assign hit         = pend_valid && (pend_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_data[l*LANE_W +: LANE_W] = (hit && pend_mask[l])
                                         ? pend_data[l*LANE_W +: LANE_W]
                                         : arr_data[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int AW     = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    load_n,
  input  logic                    rd_wr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    burst_il,
  input  logic                    out_en_n,
  input  logic                    doze,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drive
);

  localparam int DW = LANES * LANE_W;

  logic              step;
  logic              sel_ok;
  logic              load;
  logic              stop;
  logic              live;
  logic              acc_valid;
  logic              acc_write;
  logic [LANES-1:0]  acc_mask;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  commit_we;
  logic [MEM_AW-1:0] commit_addr;
  logic [DW-1:0]     commit_data;
  logic [DW-1:0]     arr_data;
  logic              rd_drive;

  assign step   = ~run_n & ~doze;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  zbt_cmd_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load_n    (load_n),
    .sel_ok    (sel_ok),
    .rd_wr     (rd_wr),
    .lane_wr_n (lane_wr_n),
    .live      (live),
    .load      (load),
    .stop      (stop),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_mask  (acc_mask)
  );

  zbt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .stop     (stop),
    .addr_in  (addr),
    .order_il (burst_il),
    .cur_addr (cur_addr),
    .live     (live)
  );

  zbt_wr_stage #(
    .ADDR_W (ADDR_W),
    .ARR_AW (MEM_AW),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .capture     (acc_valid & acc_write),
    .cap_addr    (cur_addr),
    .cap_data    (din),
    .cap_mask    (acc_mask),
    .rd_addr     (cur_addr),
    .arr_data    (arr_data),
    .commit_we   (commit_we),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .rd_data     (dout)
  );

  zbt_lane_array #(
    .AW     (MEM_AW),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_arr (
    .clk   (clk),
    .we    (commit_we),
    .waddr (commit_addr),
    .wdata (commit_data),
    .raddr (cur_addr[MEM_AW-1:0]),
    .rdata (arr_data)
  );

  assign rd_drive   = acc_valid & ~acc_write;
  assign dout_drive = rd_drive & ~out_en_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_n,
  input logic          doze,
  input logic          load_n,
  input logic          rd_wr,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          out_en_n,
  input logic          rd_drive,
  input logic          dout_drive,
  input logic [DW-1:0] dout
);

  logic go, sel_all;
  assign go      = ~run_n & ~doze;
  assign sel_all = ~sel_a_n & sel_b & ~sel_c_n;

  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load_n && sel_all && rd_wr) |=> rd_drive);                 // R3

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load_n && sel_all && !rd_wr) |=> !dout_drive);             // R8

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !load_n && !sel_all) |=> !dout_drive);                      // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && rd_drive) |=> (rd_drive && $stable(dout)));              // R6

  AST_DOZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (doze && rd_drive) |=> (rd_drive && $stable(dout)));               // R12

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dout_drive);                                         // R11

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !rd_drive);                                             // R13

endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_n      (run_n),
  .doze       (doze),
  .load_n     (load_n),
  .rd_wr      (rd_wr),
  .sel_a_n    (sel_a_n),
  .sel_b      (sel_b),
  .sel_c_n    (sel_c_n),
  .out_en_n   (out_en_n),
  .rd_drive   (rd_drive),
  .dout_drive (dout_drive),
  .dout       (dout)
);

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;
  localparam int AW = 8, MAW = 6, LN = 2, LW = 9, DW = LN * LW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b1, run_n = 1'b1, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic load_n = 1'b1, rd_wr = 1'b1, burst_il = 1'b0, out_en_n = 1'b1, doze = 1'b0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_drive;

  zbt_sram #(.ADDR_W(AW), .MEM_AW(MAW), .LANES(LN), .LANE_W(LW)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .load_n(load_n), .rd_wr(rd_wr), .lane_wr_n(lane_wr_n),
    .burst_il(burst_il), .out_en_n(out_en_n), .doze(doze), .addr(addr),
    .din(din), .dout(dout), .dout_drive(dout_drive)
  );

  int total = 0, bad = 0, wcount = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [64];
  logic m_valid = 1'b0, m_wr = 1'b0, m_live = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic [LN-1:0] m_mask = '0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] off;
    off = burst_il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], off};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: inputs applied, edge, model update, outputs sampled 2 ns later.
  task automatic step(input bit ldn, input bit rw, input logic [LN-1:0] wen,
                      input int a, input int desel, input bit ckn, input bit slp,
                      input bit oen, input string req);
    logic exp_en;
    logic [AW-1:0] ma;
    load_n = ldn; rd_wr = rw; lane_wr_n = wen; addr = AW'(a);
    run_n = ckn; doze = slp; out_en_n = oen;
    sel_a_n = (desel == 1); sel_b = (desel != 2); sel_c_n = (desel == 3);
    @(posedge clk);
    if (!ckn && !slp) begin
      if (m_valid && m_wr) begin
        ma = m_addr();
        for (int l = 0; l < LN; l++)
          if (m_mask[l]) ref_mem[ma[MAW-1:0]][l*LW +: LW] = din[l*LW +: LW];
      end
      if (!ldn) begin
        if (desel == 0) begin
          m_base = AW'(a); m_beat = 2'd0; m_live = 1'b1; m_valid = 1'b1; m_wr = !rw;
        end else begin
          m_live = 1'b0; m_valid = 1'b0;
        end
      end else if (m_live) begin
        m_beat = m_beat + 2'd1; m_valid = 1'b1;
      end else begin
        m_valid = 1'b0;
      end
      m_mask = ~wen;
    end
    #2;
    exp_en = m_valid && !m_wr && !oen;
    chk(dout_drive === exp_en, req, DW'(dout_drive), DW'(exp_en));
    if (exp_en) begin
      ma = m_addr();
      chk(dout === ref_mem[ma[MAW-1:0]], req, dout, ref_mem[ma[MAW-1:0]]);
    end
    wcount++;
    din = DW'((wcount * 40503 + 977) >> 2);
  endtask

  task automatic burst(input bit rw, input logic [LN-1:0] wen, input int a, input string req);
    step(1'b0, rw, wen, a, 0, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 3; i++) step(1'b1, rw, wen, 0, 0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic desel_step(input int kind);
    step(1'b0, 1'b1, 2'b11, 0, kind, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(dout_drive === 1'b0, "R13", DW'(dout_drive), '0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, "R13");

    for (int il = 0; il < 2; il++) begin
      string ord_req;
      ord_req = (il == 1) ? "R5" : "R4";
      burst_il = il[0];
      // full fill with back-to-back write bursts, no gap cycles
      for (int b = 0; b < 16; b++) burst(1'b0, 2'b00, b * 4 + (b + il) % 4, "R2");
      desel_step(1);
      // read every group from every start offset
      for (int b = 0; b < 16; b++)
        for (int s = 0; s < 4; s++) burst(1'b1, 2'b11, b * 4 + s, ord_req);
      desel_step(2);
      // lane writes immediately followed by a read of the same word
      for (int a = 0; a < 16; a++) begin
        logic [LN-1:0] wm;
        wm = (a % 3 == 0) ? 2'b01 : (a % 3 == 1) ? 2'b10 : 2'b00;
        step(1'b0, 1'b0, wm, a * 4 + 1, 0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 2'b11, a * 4 + 1, 0, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, ord_req);
        step(1'b0, 1'b0, 2'b00, a * 4 + 2, 0, 1'b0, 1'b0, 1'b0, "R8");
      end
      desel_step(3);
      // stall and sleep in the middle of a read burst
      step(1'b0, 1'b1, 2'b11, 9, 0, 1'b0, 1'b0, 1'b0, "R3");
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, ord_req);
      step(1'b0, 1'b0, 2'b00, 50, 0, 1'b1, 1'b0, 1'b0, "R6");
      step(1'b0, 1'b0, 2'b00, 51, 3, 1'b1, 1'b0, 1'b0, "R6");
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, ord_req);
      step(1'b0, 1'b0, 2'b00, 52, 0, 1'b0, 1'b1, 1'b0, "R12");
      step(1'b0, 1'b0, 2'b00, 53, 0, 1'b0, 1'b1, 1'b0, "R12");
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, ord_req);
      // stalled write burst: data taken only on enabled edges
      step(1'b0, 1'b0, 2'b00, 20, 0, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b1, 1'b0, 2'b00, 0, 0, 1'b1, 1'b0, 1'b0, "R6");
      step(1'b1, 1'b0, 2'b00, 0, 0, 1'b0, 1'b0, 1'b0, "R2");
      step(1'b1, 1'b0, 2'b00, 0, 0, 1'b0, 1'b1, 1'b0, "R12");
      step(1'b1, 1'b0, 2'b00, 0, 0, 1'b0, 1'b0, 1'b0, "R2");
      // deselect mid write burst; the pending beat still lands
      step(1'b0, 1'b0, 2'b00, 32, 0, 1'b0, 1'b0, 1'b0, "R1");
      step(1'b1, 1'b0, 2'b00, 0, 0, 1'b0, 1'b0, 1'b0, "R2");
      desel_step(2);
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, "R7");
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, "R7");
      burst(1'b1, 2'b11, 32, "R7");
      burst(1'b1, 2'b11, 20, "R6");
      // output enable, synchronous and asynchronous
      step(1'b0, 1'b1, 2'b11, 40, 0, 1'b0, 1'b0, 1'b1, "R11");
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b0, "R11");
      out_en_n = 1'b1; #1;
      chk(dout_drive === 1'b0, "R11", DW'(dout_drive), '0);
      out_en_n = 1'b0; #1;
      chk(dout_drive === 1'b1, "R11", DW'(dout_drive), DW'(1));
      step(1'b1, 1'b1, 2'b11, 0, 0, 1'b0, 1'b0, 1'b1, "R11");
      desel_step(1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule